// File: doc/BRIEF.md
# Automatic Transmit/Receive Pin Switcher

This block switches groups of general-purpose pins between two preset patterns according to whether a transmit path is busy. A radio front end often needs antenna switches, amplifier enables and similar lines to change with the transmit direction. Here software does not toggle those lines. The block watches the empty flag of the transmit FIFO and treats "FIFO holds data" as the raw transmit condition. It then delays that condition by programmable clock counts, with one count for entering transmit and another for leaving it. The delayed state picks, for each pin bank, either a transmit pattern or a receive pattern.

Each of four 16-bit banks has a mask, a transmit pattern and a receive pattern. The block produces a per-bank override mask and an override value. A downstream GPIO block uses these to replace its own output on the masked pins. Unmasked pins keep their ordinary GPIO value. Configuration arrives over a simple write port that carries an address and a 32-bit data word. A control register holds an enable bit that turns the whole function on or off.

Top module: `atr_switcher`

## Requirements
- R1: After reset all masks, patterns, delays and the enable are zero, `tx_active` is 0 and both override outputs are all zero.
- R2: A write is taken on a clock edge where `wr_en` is 1. For bank n, the mask is at address 20+3n, the transmit pattern at 21+3n and the receive pattern at 22+3n. Each takes the low 16 bits of `wr_data` and ignores the upper bits. The enter-transmit delay is at address 2 and the leave-transmit delay at address 3, each taking the low 8 bits. The enable is bit 0 at address 32.
- R3: While enabled, bank n of `ovr_mask` (bits 16n+15..16n) equals that bank's mask. While disabled, `ovr_mask` is all zero.
- R4: While enabled, bank n of `ovr_val` equals the transmit pattern ANDed with the mask when `tx_active` is 1, and the receive pattern ANDed with the mask when it is 0. While disabled, `ovr_val` is all zero.
- R5: The raw transmit condition is true only when the block is enabled and `txfifo_empty` is 0. While disabled, a non-empty FIFO never raises `tx_active`.
- R6: Let the first clock edge that samples the raw condition as true while `tx_active` is 0 be edge 0. With enter delay D, `tx_active` becomes 1 on edge D, so D=0 switches on edge 0 itself.
- R7: Let the first clock edge that samples the raw condition as false while `tx_active` is 1 be edge 0. With leave delay D, `tx_active` becomes 0 on edge D.
- R8: If the raw condition returns to the current state before the delay expires, `tx_active` does not change. A later change starts the full delay again.
- R9: Once the edge that clears the enable has passed, both override outputs are zero at once and `tx_active` is 0 from the next edge onward.
- R10: Writes to any address other than those listed in R2 change no register. Their effect is observed through the override outputs and the delays.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Configuration write strobe |
| wr_addr | input | 6 | Configuration register address |
| wr_data | input | 32 | Configuration write data |
| txfifo_empty | input | 1 | High when the transmit FIFO holds no data |
| ovr_mask | output | 64 | Per-bank override mask, bank n at bits 16n+15..16n |
| ovr_val | output | 64 | Per-bank override value, already masked |
| tx_active | output | 1 | Delayed transmit state |

## Verification
A configuration write shows on the override outputs right after the edge that takes it, because those outputs are combinational from the registers. A FIFO change reaches `tx_active` exactly D edges after the first edge that samples it. The bench drives every input on a falling edge and reads every result on the following falling edge. It counts rising edges from the one that first sees the new input, so each check falls in the cycle where the result is due. Delays from 0 to 4 are swept in both directions. At every edge of each window the bench checks that `tx_active` is still low or high as required, so an early or late switch is caught as well as a wrong final value.

// File: rtl/atr_pkg.sv
package atr_pkg;

   typedef enum logic {
      ST_RX = 1'b0,
      ST_TX = 1'b1
   } atr_state_e;

   // address of register `slot` (0 mask, 1 tx pattern, 2 rx pattern) of bank `bank`
   function automatic int bank_reg_addr(input int base, input int bank, input int slot);
      return base + 3 * bank + slot;
   endfunction

endpackage

// File: rtl/atr_cfg_regs.sv
module atr_cfg_regs
   import atr_pkg::*;
#(
   parameter int NUM_BANKS = 4,
   parameter int BANK_W    = 16,
   parameter int ADDR_W    = 6,
   parameter int DATA_W    = 32,
   parameter int DLY_W     = 8,
   parameter int BANK_BASE = 20,
   parameter int TXDLY_ADR = 2,
   parameter int RXDLY_ADR = 3,
   parameter int CTRL_ADR  = 32
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        wr_en,
   input  logic [ADDR_W-1:0]           wr_addr,
   input  logic [DATA_W-1:0]           wr_data,
   output logic                        en_o,
   output logic [DLY_W-1:0]            tx_dly_o,
   output logic [DLY_W-1:0]            rx_dly_o,
   output logic [NUM_BANKS*BANK_W-1:0] mask_o,
   output logic [NUM_BANKS*BANK_W-1:0] txv_o,
   output logic [NUM_BANKS*BANK_W-1:0] rxv_o
);

   localparam int LAST_ADR = BANK_BASE + 3 * NUM_BANKS - 1;

   if (BANK_W > DATA_W || DLY_W > DATA_W) begin : g_bad_width
      $error("atr_cfg_regs: register field wider than data word");
   end
   if (LAST_ADR >= (1 << ADDR_W) || CTRL_ADR >= (1 << ADDR_W)) begin : g_bad_addr
      $error("atr_cfg_regs: register map does not fit the address width");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_o     <= 1'b0;
         tx_dly_o <= '0;
         rx_dly_o <= '0;
      end else if (wr_en) begin
         if (wr_addr == ADDR_W'(CTRL_ADR))  en_o     <= wr_data[0];
         if (wr_addr == ADDR_W'(TXDLY_ADR)) tx_dly_o <= wr_data[DLY_W-1:0];
         if (wr_addr == ADDR_W'(RXDLY_ADR)) rx_dly_o <= wr_data[DLY_W-1:0];
      end
   end

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(bank_reg_addr(BANK_BASE, b, 0));
      localparam logic [ADDR_W-1:0] A_TXV  = ADDR_W'(bank_reg_addr(BANK_BASE, b, 1));
      localparam logic [ADDR_W-1:0] A_RXV  = ADDR_W'(bank_reg_addr(BANK_BASE, b, 2));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            mask_o[b*BANK_W +: BANK_W] <= '0;
            txv_o [b*BANK_W +: BANK_W] <= '0;
            rxv_o [b*BANK_W +: BANK_W] <= '0;
         end else if (wr_en) begin
            if (wr_addr == A_MASK) mask_o[b*BANK_W +: BANK_W] <= wr_data[BANK_W-1:0];
            if (wr_addr == A_TXV)  txv_o [b*BANK_W +: BANK_W] <= wr_data[BANK_W-1:0];
            if (wr_addr == A_RXV)  rxv_o [b*BANK_W +: BANK_W] <= wr_data[BANK_W-1:0];
         end
      end
   end

endmodule

// File: rtl/atr_delay_ctl.sv
module atr_delay_ctl
   import atr_pkg::*;
#(
   parameter int DLY_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             raw_tx,
   input  logic [DLY_W-1:0] tx_dly,
   input  logic [DLY_W-1:0] rx_dly,
   output logic             tx_state
);

   if (DLY_W < 1) begin : g_bad_dly
      $error("atr_delay_ctl: DLY_W must be at least 1");
   end

   atr_state_e       state_q;
   atr_state_e       raw_st;
   logic             pend_q;
   logic [DLY_W-1:0] cnt_q;
   logic [DLY_W-1:0] dly_sel;

   assign raw_st   = raw_tx ? ST_TX : ST_RX;
   assign dly_sel  = raw_tx ? tx_dly : rx_dly;
   assign tx_state = (state_q == ST_TX);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_RX;
         pend_q  <= 1'b0;
         cnt_q   <= '0;
      end else if (!en) begin
         state_q <= ST_RX;
         pend_q  <= 1'b0;
         cnt_q   <= '0;
      end else if (raw_st == state_q) begin
         pend_q  <= 1'b0;              // revert or idle: drop any pending change
      end else if (!pend_q) begin
         if (dly_sel == '0) begin
            state_q <= raw_st;
         end else begin
            pend_q  <= 1'b1;
            cnt_q   <= dly_sel - 1'b1;
         end
      end else if (cnt_q == '0) begin
         state_q <= raw_st;
         pend_q  <= 1'b0;
      end else begin
         cnt_q   <= cnt_q - 1'b1;
      end
   end

   assert_disable_rx_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !tx_state);

   assert_hold_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (en && pend_q && cnt_q != '0) |=> $stable(tx_state));

   assert_no_spurious_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (en && (raw_tx == tx_state)) |=> $stable(tx_state));

   assert_zero_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (en && raw_tx && !tx_state && !pend_q && tx_dly == '0) |=> tx_state);

   assert_zero_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !raw_tx && tx_state && !pend_q && rx_dly == '0) |=> !tx_state);

endmodule

// File: rtl/atr_bank_sel.sv
module atr_bank_sel #(
   parameter int BANK_W = 16
) (
   input  logic              en,
   input  logic              tx_state,
   input  logic [BANK_W-1:0] mask,
   input  logic [BANK_W-1:0] txv,
   input  logic [BANK_W-1:0] rxv,
   output logic [BANK_W-1:0] o_mask,
   output logic [BANK_W-1:0] o_val
);

   logic [BANK_W-1:0] pick;

   assign pick   = tx_state ? txv : rxv;
   assign o_mask = en ? mask : '0;
   assign o_val  = en ? (pick & mask) : '0;

   always_comb begin
      assert_val_in_mask_R4: assert ((o_val & ~o_mask) == '0);
   end

endmodule

// File: rtl/atr_switcher.sv
module atr_switcher
   import atr_pkg::*;
#(
   parameter int NUM_BANKS = 4,
   parameter int BANK_W    = 16,
   parameter int ADDR_W    = 6,
   parameter int DATA_W    = 32,
   parameter int DLY_W     = 8
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        wr_en,
   input  logic [ADDR_W-1:0]           wr_addr,
   input  logic [DATA_W-1:0]           wr_data,
   input  logic                        txfifo_empty,
   output logic [NUM_BANKS*BANK_W-1:0] ovr_mask,
   output logic [NUM_BANKS*BANK_W-1:0] ovr_val,
   output logic                        tx_active
);

   localparam int FLAT_W = NUM_BANKS * BANK_W;

   if (NUM_BANKS < 1) begin : g_bad_banks
      $error("atr_switcher: NUM_BANKS must be at least 1");
   end

   logic              en;
   logic [DLY_W-1:0]  tx_dly, rx_dly;
   logic [FLAT_W-1:0] mask_f, txv_f, rxv_f;
   logic              raw_tx;

   atr_cfg_regs #(
      .NUM_BANKS (NUM_BANKS),
      .BANK_W    (BANK_W),
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W),
      .DLY_W     (DLY_W)
   ) u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .en_o     (en),
      .tx_dly_o (tx_dly),
      .rx_dly_o (rx_dly),
      .mask_o   (mask_f),
      .txv_o    (txv_f),
      .rxv_o    (rxv_f)
   );

   assign raw_tx = en & ~txfifo_empty;

   atr_delay_ctl #(.DLY_W(DLY_W)) u_dly (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (en),
      .raw_tx   (raw_tx),
      .tx_dly   (tx_dly),
      .rx_dly   (rx_dly),
      .tx_state (tx_active)
   );

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_sel
      atr_bank_sel #(.BANK_W(BANK_W)) u_sel (
         .en       (en),
         .tx_state (tx_active),
         .mask     (mask_f[b*BANK_W +: BANK_W]),
         .txv      (txv_f [b*BANK_W +: BANK_W]),
         .rxv      (rxv_f [b*BANK_W +: BANK_W]),
         .o_mask   (ovr_mask[b*BANK_W +: BANK_W]),
         .o_val    (ovr_val [b*BANK_W +: BANK_W])
      );
   end

   assert_fifo_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!tx_active && txfifo_empty) |=> !tx_active);

endmodule

// File: tb/sim_atr_switcher.sv
module sim_atr_switcher;

   localparam int NB = 4, BW = 16, AW = 6, DW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic          txfifo_empty = 1'b1;
   logic [NB*BW-1:0] ovr_mask, ovr_val;
   logic          tx_active;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   logic [BW-1:0] m_p [NB];
   logic [BW-1:0] t_p [NB];
   logic [BW-1:0] r_p [NB];

   always #10 clk = ~clk;

   atr_switcher u0 (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr_en        (wr_en),
      .wr_addr      (wr_addr),
      .wr_data      (wr_data),
      .txfifo_empty (txfifo_empty),
      .ovr_mask     (ovr_mask),
      .ovr_val      (ovr_val),
      .tx_active    (tx_active)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input int a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic chk_outs(input string req, input bit en, input bit tx);
      logic [NB*BW-1:0] em, ev;
      for (int b = 0; b < NB; b++) begin
         em[b*BW +: BW] = en ? m_p[b] : '0;
         ev[b*BW +: BW] = en ? ((tx ? t_p[b] : r_p[b]) & m_p[b]) : '0;
      end
      chk({req, " mask"}, 64'(ovr_mask), 64'(em));
      chk({req, " val"},  64'(ovr_val),  64'(ev));
      chk({req, " state"}, 64'(tx_active), 64'(tx));
   endtask

   // drive the FIFO toward `to_tx` and track tx_active edge by edge
   task automatic edge_run(input string req, input bit to_tx, input int d);
      txfifo_empty = !to_tx;
      for (int k = 0; k <= d + 1; k++) begin
         @(posedge clk); @(negedge clk);
         chk(req, 64'(tx_active), 64'((k >= d) ? to_tx : !to_tx));
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      for (int b = 0; b < NB; b++) begin
         m_p[b] = 16'hA5C3 ^ BW'(b * 16'h1111);
         t_p[b] = BW'((b + 1) * 16'h1357);
         r_p[b] = ~t_p[b] ^ 16'h0F0F;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk("R1 mask", 64'(ovr_mask), 64'h0);
      chk("R1 val",  64'(ovr_val),  64'h0);
      chk("R1 state", 64'(tx_active), 64'h0);

      // R2: load banks with junk in the upper half-word
      for (int b = 0; b < NB; b++) begin
         wr(20 + 3 * b, {16'hDEAD, m_p[b]});
         wr(21 + 3 * b, {16'hBEEF, t_p[b]});
         wr(22 + 3 * b, {16'hCAFE, r_p[b]});
      end
      chk_outs("R3 disabled", 1'b0, 1'b0);
      wr(32, 32'h1);
      chk_outs("R2 R3 R4 enabled rx", 1'b1, 1'b0);

      // R6 R7: sweep both delays
      for (int dt = 0; dt <= 4; dt++) begin
         for (int dr = 0; dr <= 4; dr++) begin
            wr(2, 32'(dt));
            wr(3, 32'(dr));
            edge_run("R6 rise timing", 1'b1, dt);
            chk_outs("R4 tx pattern", 1'b1, 1'b1);
            edge_run("R7 fall timing", 1'b0, dr);
            chk_outs("R4 rx pattern", 1'b1, 1'b0);
         end
      end

      // R8: cancelled rise, then full restart
      wr(2, 32'd5);
      txfifo_empty = 1'b0;
      for (int k = 0; k < 3; k++) begin
         @(posedge clk); @(negedge clk);
         chk("R8 short pulse", 64'(tx_active), 64'h0);
      end
      txfifo_empty = 1'b1;
      for (int k = 0; k < 8; k++) begin
         @(posedge clk); @(negedge clk);
         chk("R8 cancelled rise", 64'(tx_active), 64'h0);
      end
      edge_run("R8 restart rise", 1'b1, 5);

      // R8: cancelled fall
      wr(3, 32'd4);
      txfifo_empty = 1'b1;
      for (int k = 0; k < 2; k++) begin
         @(posedge clk); @(negedge clk);
         chk("R8 short gap", 64'(tx_active), 64'h1);
      end
      txfifo_empty = 1'b0;
      for (int k = 0; k < 6; k++) begin
         @(posedge clk); @(negedge clk);
         chk("R8 cancelled fall", 64'(tx_active), 64'h1);
      end

      // R9: disable while transmitting
      wr(32, 32'h0);
      chk("R9 mask off", 64'(ovr_mask), 64'h0);
      chk("R9 val off",  64'(ovr_val),  64'h0);
      @(posedge clk); @(negedge clk);
      chk("R9 state rx", 64'(tx_active), 64'h0);

      // R5: non-empty FIFO while disabled
      for (int k = 0; k < 10; k++) begin
         @(posedge clk); @(negedge clk);
         chk("R5 gated", 64'(tx_active), 64'h0);
      end
      wr(2, 32'd0);
      wr(32, 32'h1);
      chk("R5 still rx after enable edge", 64'(tx_active), 64'h0);
      @(posedge clk); @(negedge clk);
      chk("R5 R6 enabled rise", 64'(tx_active), 64'h1);

      // R10: writes to unmapped addresses
      for (int a = 0; a < 64; a++) begin
         if (!(a == 2 || a == 3 || a == 32 || (a >= 20 && a <= 31)))
            wr(a, 32'hFFFF_FFFF);
      end
      chk_outs("R10 banks kept", 1'b1, 1'b1);
      edge_run("R10 rx delay kept", 1'b0, 4);
      edge_run("R10 tx delay kept", 1'b1, 0);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule